// File: doc/BRIEF.md
# Six-Output PWM Generator with Deadband

This block drives six pulse-width-modulated outputs from one shared period counter. A programmable divider produces a timing tick from the system clock, and the 12-bit counter advances by one step on each tick. It either counts upward and wraps for edge-aligned waveforms, or counts up and then back down for center-aligned waveforms. Each output compares a signed 16-bit duty value with the current count. A duty of zero or below turns the output off for the whole period. A duty above the reload value turns it on for the whole period.

The outputs can work as six independent channels, each with its own duty value. They can also work as three complementary high/low pairs. In that case only the even channel's duty value of each pair is used, a per-pair polarity bit picks which side starts the period on, and a programmable deadband holds both sides of a pair off around every switch. Reload, duty, counting mode, pairing mode and polarity are captured into shadow registers when a new period starts, so that a change made mid-period never cuts a pulse short. A one-cycle strobe marks the start of each period. The prescaler and deadband inputs take effect at once.

Top module: `pwm6_gen`

## Requirements
- R1: The counter advances once every `max(prescale_i,1)` clock cycles. `prd_o` is high for exactly one clock cycle, in the first cycle of each period, while the count is 0.
- R2: In edge-aligned mode (`center_i`=0), with reload R ≥ 1, the count runs 0,1,…,R-1 and then starts a new period, so a period lasts R steps.
- R3: In center-aligned mode (`center_i`=1), with reload R ≥ 1, the count runs 0,1,…,R,R-1,…,1 and then starts a new period, so a period lasts 2·R steps.
- R4: A duty field is two's complement with bit 15 as the sign. A channel is on while the count is below the duty value, and a duty ≤ 0 keeps it off for the whole period.
- R5: A duty value greater than the reload value keeps the channel on for the whole period, whichever counting mode is in use.
- R6: Reload, duty, counting mode, pairing mode and polarity are captured only at a period start. Changes made in the middle of a period do not affect that period.
- R7: With `inden_i`=1, `pwm_o[k]` follows the duty field `duty_i[16k+15:16k]`, and `pol_i` has no effect.
- R8: With `inden_i`=0, pair p drives its high side on `pwm_o[2p]` and its low side on `pwm_o[2p+1]`, both from the duty field of channel 2p. The duty fields of odd channels have no effect.
- R9: In complementary mode with `pol_i[p]`=0, the high side of pair p is the one that is on while the count is below the duty value. With `pol_i[p]`=1 the two sides swap.
- R10: In complementary mode, after the wanted state of a pair changes, both of its outputs stay off for `dband_i` ticks before the new side turns on. With `dband_i`=0 the switch is immediate. The two sides of a pair are never on together.
- R11: While `rst_n` is low, all outputs are low. After release, the first period starts within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reload_i | input | 12 | Period reload value R |
| prescale_i | input | 8 | Clock cycles per counter step (0 acts as 1) |
| duty_i | input | 96 | Six signed 16-bit duty values, channel k at bits [16k+15:16k] |
| center_i | input | 1 | 1 selects center-aligned counting, 0 selects edge-aligned |
| inden_i | input | 1 | 1 selects six independent channels, 0 selects three complementary pairs |
| pol_i | input | 3 | Per-pair polarity swap |
| dband_i | input | 8 | Deadband length in counter ticks |
| pwm_o | output | 6 | PWM outputs, pair p high side at 2p and low side at 2p+1 |
| prd_o | output | 1 | One-cycle strobe at each period start |

## Verification
The hardest case to reach from the ports is a deadband gap that crosses a period boundary, or that restarts because the wanted state changes again before the gap has ended. Both depend on how the duty value, the reload value, the counting mode and the prescaler combine. The bench sweeps duty values that put edges at count 0, just below the reload value and beyond it, in both counting modes, with prescaler values of 1 and 2 and deadband lengths of 0 to 2. It predicts each output from a per-pair count of ticks since the last change of the wanted state, and that count is carried without a break across period starts.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;

  // direction of the period counter
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  // per-period mode settings captured at the period start
  typedef struct packed {
    logic center;
    logic inden;
  } tb_mode_t;

endpackage

// File: rtl/pwm6_prescale.sv
module pwm6_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] pcnt_q, pcnt_d;
  logic             last;

  always_comb begin
    last   = (div_i <= PSC_W'(1)) || (pcnt_q >= (div_i - PSC_W'(1)));
    tick_o = last;
    pcnt_d = last ? '0 : pcnt_q + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/pwm6_timebase.sv
module pwm6_timebase
  import pwm6_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             center_i,
  input  logic             inden_i,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_d,
  output logic [CNT_W-1:0] reload_q,
  output logic             load_o,
  output logic             inden_q,
  output logic             inden_eff_o,
  output logic             prd_o
);

  cnt_dir_e         dir_q, dir_d, dir_nx;
  tb_mode_t         mode_q, mode_d;
  logic [CNT_W-1:0] count_nx;
  logic [CNT_W-1:0] reload_d;
  logic             wrap;
  logic             prd_q, prd_d;

  // step rule for the next tick
  always_comb begin
    wrap     = 1'b0;
    count_nx = count_q + CNT_W'(1);
    dir_nx   = dir_q;
    if (!mode_q.center) begin
      if (({1'b0, count_q} + (CNT_W+1)'(1)) >= {1'b0, reload_q}) begin
        wrap     = 1'b1;
        count_nx = '0;
      end
    end else if (dir_q == CNT_UP) begin
      if (count_q >= reload_q) begin
        if (reload_q <= CNT_W'(1)) begin
          wrap     = 1'b1;
          count_nx = '0;
        end else begin
          count_nx = reload_q - CNT_W'(1);
          dir_nx   = CNT_DOWN;
        end
      end
    end else begin
      if (count_q <= CNT_W'(1)) begin
        wrap     = 1'b1;
        count_nx = '0;
        dir_nx   = CNT_UP;
      end else begin
        count_nx = count_q - CNT_W'(1);
      end
    end
  end

  // next state with the tick as clock enable
  always_comb begin
    load_o   = tick_i && wrap;
    count_d  = tick_i ? count_nx : count_q;
    dir_d    = tick_i ? (wrap ? CNT_UP : dir_nx) : dir_q;
    reload_d = load_o ? reload_i : reload_q;
    mode_d   = mode_q;
    if (load_o) begin
      mode_d.center = center_i;
      mode_d.inden  = inden_i;
    end
    prd_d       = load_o;
    inden_eff_o = mode_d.inden;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      dir_q    <= CNT_UP;
      reload_q <= '0;
      mode_q   <= '0;
      prd_q    <= 1'b0;
    end else begin
      count_q  <= count_d;
      dir_q    <= dir_d;
      reload_q <= reload_d;
      mode_q   <= mode_d;
      prd_q    <= prd_d;
    end
  end

  assign inden_q = mode_q.inden;
  assign prd_o   = prd_q;

endmodule

// File: rtl/pwm6_pair.sv
module pwm6_pair #(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 16,
  parameter int DB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DUTY_W-1:0] duty_h_i,
  input  logic [DUTY_W-1:0] duty_l_i,
  input  logic              pol_i,
  input  logic              inden_i,
  input  logic [DB_W-1:0]   dband_i,
  output logic              hi_o,
  output logic              lo_o
);

  localparam int MAG_W = DUTY_W - 1;

  logic [DUTY_W-1:0] duty_h_q, duty_l_q, duty_h_eff, duty_l_eff;
  logic              pol_q, pol_eff;
  logic              raw_h, raw_l, want;
  logic              tgt_q, tgt_d;
  logic [DB_W-1:0]   db_q, db_d;
  logic              cmp_hi, cmp_lo;
  logic              hi_q, hi_d, lo_q, lo_d;

  // signed duty against unsigned count: negative never wins
  function automatic logic duty_on(input logic [DUTY_W-1:0] duty,
                                   input logic [CNT_W-1:0]  cnt);
    return !duty[DUTY_W-1] && (MAG_W'(cnt) < duty[MAG_W-1:0]);
  endfunction

  always_comb begin
    duty_h_eff = ld_i ? duty_h_i : duty_h_q;
    duty_l_eff = ld_i ? duty_l_i : duty_l_q;
    pol_eff    = ld_i ? pol_i    : pol_q;
    raw_h      = duty_on(duty_h_eff, count_i);
    raw_l      = duty_on(duty_l_eff, count_i);
    want       = raw_h ^ pol_eff;
  end

  // deadband sequencing, evaluated for the coming tick
  always_comb begin
    tgt_d  = tgt_q;
    db_d   = db_q;
    cmp_hi = 1'b0;
    cmp_lo = 1'b0;
    if (want != tgt_q) begin
      tgt_d = want;
      if (dband_i == '0) begin
        db_d   = '0;
        cmp_hi = want;
        cmp_lo = !want;
      end else begin
        db_d = dband_i;
      end
    end else if (db_q > DB_W'(1)) begin
      db_d = db_q - DB_W'(1);
    end else begin
      db_d   = '0;
      cmp_hi = tgt_q;
      cmp_lo = !tgt_q;
    end
    hi_d = inden_i ? raw_h : cmp_hi;
    lo_d = inden_i ? raw_l : cmp_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_h_q <= '0;
      duty_l_q <= '0;
      pol_q    <= 1'b0;
      tgt_q    <= 1'b0;
      db_q     <= '0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else begin
      if (ld_i) begin
        duty_h_q <= duty_h_i;
        duty_l_q <= duty_l_i;
        pol_q    <= pol_i;
      end
      if (tick_i) begin
        tgt_q <= tgt_d;
        db_q  <= db_d;
        hi_q  <= hi_d;
        lo_q  <= lo_d;
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

endmodule

// File: rtl/pwm6_gen.sv
module pwm6_gen #(
  parameter int CNT_W  = 12,
  parameter int DUTY_W = 16,
  parameter int PSC_W  = 8,
  parameter int DB_W   = 8,
  parameter int NPAIR  = 3,
  localparam int NCH   = 2 * NPAIR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      reload_i,
  input  logic [PSC_W-1:0]      prescale_i,
  input  logic [NCH*DUTY_W-1:0] duty_i,
  input  logic                  center_i,
  input  logic                  inden_i,
  input  logic [NPAIR-1:0]      pol_i,
  input  logic [DB_W-1:0]       dband_i,
  output logic [NCH-1:0]        pwm_o,
  output logic                  prd_o
);

  logic             rst_meta_q, rst_sync_n;
  logic             tick;
  logic             load;
  logic             inden_q, inden_eff;
  logic [CNT_W-1:0] count_q, count_d, reload_q;
  logic [NPAIR-1:0] hi_w, lo_w;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pwm6_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .div_i  (prescale_i),
    .tick_o (tick)
  );

  pwm6_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick_i      (tick),
    .reload_i    (reload_i),
    .center_i    (center_i),
    .inden_i     (inden_i),
    .count_q     (count_q),
    .count_d     (count_d),
    .reload_q    (reload_q),
    .load_o      (load),
    .inden_q     (inden_q),
    .inden_eff_o (inden_eff),
    .prd_o       (prd_o)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm6_pair #(
      .CNT_W  (CNT_W),
      .DUTY_W (DUTY_W),
      .DB_W   (DB_W)
    ) u_pair (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .tick_i   (tick),
      .ld_i     (load),
      .count_i  (count_d),
      .duty_h_i (duty_i[(2*p)*DUTY_W +: DUTY_W]),
      .duty_l_i (duty_i[(2*p+1)*DUTY_W +: DUTY_W]),
      .pol_i    (pol_i[p]),
      .inden_i  (inden_eff),
      .dband_i  (dband_i),
      .hi_o     (hi_w[p]),
      .lo_o     (lo_w[p])
    );
    assign pwm_o[2*p]   = hi_w[p];
    assign pwm_o[2*p+1] = lo_w[p];
  end

endmodule

// File: rtl/pwm6_gen_chk.sv
module pwm6_gen_chk #(
  parameter int NCH   = 6,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   pwm_o,
  input logic             prd_o,
  input logic             tick,
  input logic             inden_q,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] reload_q
);

  // R11: outputs quiet during reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |-> (pwm_o == '0 && !prd_o));

  // R1: strobe only while the count sits at zero
  p_strobe_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prd_o |-> (count_q == '0));

  // R1: the count moves only on a tick
  p_hold_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));

  // R2/R3: the count never passes the captured reload
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= reload_q);

  // R6: captured settings change only at a period start
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !prd_o |-> ($stable(reload_q) && $stable(inden_q)));

  // R10: the two sides of a pair are never on together
  p_pair_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inden_q |-> ((pwm_o[0] & pwm_o[1]) | (pwm_o[2] & pwm_o[3]) |
                  (pwm_o[4] & pwm_o[5])) == 1'b0);

endmodule

bind pwm6_gen pwm6_gen_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_o    (pwm_o),
  .prd_o    (prd_o),
  .tick     (tick),
  .inden_q  (inden_q),
  .count_q  (count_q),
  .reload_q (reload_q)
);

// File: tb/pwm6_gen_bench.sv
module pwm6_gen_bench;

  localparam int CNT_W  = 12;
  localparam int DUTY_W = 16;
  localparam int PSC_W  = 8;
  localparam int DB_W   = 8;
  localparam int NPAIR  = 3;
  localparam int NCH    = 6;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [CNT_W-1:0]      reload_i;
  logic [PSC_W-1:0]      prescale_i;
  logic [NCH*DUTY_W-1:0] duty_i;
  logic                  center_i, inden_i;
  logic [NPAIR-1:0]      pol_i;
  logic [DB_W-1:0]       dband_i;
  logic [NCH-1:0]        pwm_o;
  logic                  prd_o;

  always #2 clk = ~clk;

  pwm6_gen u_pwm6_gen (
    .clk(clk), .rst_n(rst_n), .reload_i(reload_i), .prescale_i(prescale_i),
    .duty_i(duty_i), .center_i(center_i), .inden_i(inden_i), .pol_i(pol_i),
    .dband_i(dband_i), .pwm_o(pwm_o), .prd_o(prd_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // values driven on the inputs
  int in_R, in_P, in_D, in_pol;
  bit in_center, in_inden;
  int in_duty[NCH];
  // values the model believes are captured
  int m_R, m_P, m_D, m_pol;
  bit m_center, m_inden;
  int m_duty[NCH];
  // deadband model: ticks since the wanted state last changed
  int run[NPAIR];
  bit pw[NPAIR];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_inputs();
    reload_i   = CNT_W'(in_R);
    prescale_i = PSC_W'(in_P);
    dband_i    = DB_W'(in_D);
    pol_i      = NPAIR'(in_pol);
    center_i   = in_center;
    inden_i    = in_inden;
    for (int k = 0; k < NCH; k++) duty_i[k*DUTY_W +: DUTY_W] = DUTY_W'(in_duty[k]);
  endtask

  task automatic latch_model();
    m_R = in_R; m_P = (in_P < 1) ? 1 : in_P; m_D = in_D; m_pol = in_pol;
    m_center = in_center; m_inden = in_inden;
    for (int k = 0; k < NCH; k++) m_duty[k] = in_duty[k];
  endtask

  task automatic sync_start(input string tag);
    int w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!prd_o && w < 2000);
    if (!prd_o) check(1'b0, tag, "no period start", 0, 1);
  endtask

  // Starts at a negedge with prd_o high; ends at the next such negedge.
  task automatic run_period(input bit do_chk, input string tag, input bit swap);
    int steps, len, s, cnt;
    bit raw[NCH];
    bit w;
    logic [NCH-1:0] expv;
    steps = m_center ? 2 * m_R : m_R;
    len   = steps * m_P;
    expv  = '0;
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      if (swap && k == len / 2) drive_inputs();
      if (k % m_P == 0) begin
        s   = k / m_P;
        cnt = (s <= m_R) ? s : 2 * m_R - s;
        for (int c = 0; c < NCH; c++) raw[c] = (m_duty[c] > 0) && (cnt < m_duty[c]);
        for (int p = 0; p < NPAIR; p++) begin
          w = raw[2*p] ^ m_pol[p];
          if (w != pw[p]) run[p] = 0;
          else if (run[p] < 100000) run[p]++;
          pw[p] = w;
          if (m_inden) begin
            expv[2*p]   = raw[2*p];
            expv[2*p+1] = raw[2*p+1];
          end else begin
            expv[2*p]   = w && (run[p] >= m_D);
            expv[2*p+1] = !w && (run[p] >= m_D);
          end
        end
      end
      if (do_chk) begin
        check(pwm_o === expv, tag, "pwm_o", longint'(pwm_o), longint'(expv));
        check(prd_o === (k == 0), "R1", "prd_o", longint'(prd_o), longint'(k == 0));
      end
    end
    @(negedge clk);
    if (do_chk) check(prd_o === 1'b1, "R1", "period length", longint'(prd_o), 1);
  endtask

  task automatic run_cfg(input string tag);
    drive_inputs();
    sync_start(tag);
    latch_model();
    run_period(1'b0, tag, 1'b0);
    run_period(1'b1, tag, 1'b0);
  endtask

  initial begin
    int waitc;
    rst_n = 1'b0;
    for (int p = 0; p < NPAIR; p++) begin run[p] = 0; pw[p] = 1'b0; end
    in_R = 4; in_P = 1; in_D = 0; in_pol = 0; in_center = 0; in_inden = 1;
    for (int k = 0; k < NCH; k++) in_duty[k] = k;
    drive_inputs();
    // R11: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(pwm_o === '0 && prd_o === 1'b0, "R11", "reset outputs",
            longint'({prd_o, pwm_o}), 0);
    end
    rst_n = 1'b1;
    waitc = 0;
    do begin
      @(negedge clk);
      waitc++;
    end while (!prd_o && waitc < 20);
    check(waitc <= 6, "R11", "cycles to first period", waitc, 6);
    latch_model();
    run_period(1'b0, "R11", 1'b0);
    run_period(1'b1, "R11 R2 R7", 1'b0);

    // independent sweep: R2 R3 R4 R5 R7
    for (int c = 0; c < 2; c++)
      for (int ri = 0; ri < 4; ri++)
        for (int pi = 0; pi < 2; pi++) begin
          int rv[4] = '{1, 2, 3, 6};
          in_R = rv[ri]; in_P = pi ? 3 : 1; in_center = c[0]; in_inden = 1; in_D = 1;
          for (int b = 0; b <= in_R + 3; b++) begin
            in_pol = b % 8;
            for (int k = 0; k < NCH; k++) in_duty[k] = b + k - 3;
            run_cfg(c ? "R3 R4 R5 R7" : "R2 R4 R5 R7");
          end
        end

    // sign extremes: R4 R5
    for (int c = 0; c < 2; c++) begin
      in_R = 5; in_P = 1; in_center = c[0]; in_inden = 1; in_pol = 7;
      in_duty[0] = -32768; in_duty[1] = 32767; in_duty[2] = 0;
      in_duty[3] = -1;     in_duty[4] = 1;     in_duty[5] = 6;
      run_cfg("R4 R5");
    end

    // prescaler value 0 acts as 1: R1
    in_R = 4; in_P = 0; in_center = 0; in_inden = 1;
    for (int k = 0; k < NCH; k++) in_duty[k] = k;
    run_cfg("R1");

    // complementary sweep: R8 R9 R10
    for (int c = 0; c < 2; c++)
      for (int ri = 0; ri < 2; ri++)
        for (int pi = 1; pi <= 2; pi++)
          for (int d = 0; d <= 2; d++)
            for (int po = 0; po < 2; po++)
              for (int bi = 0; bi < 4; bi++) begin
                int bv[4];
                in_R = ri ? 5 : 3; in_P = pi; in_D = d; in_center = c[0];
                in_inden = 0; in_pol = po ? 5 : 0;
                bv = '{0, 2, in_R, in_R + 1};
                for (int p = 0; p < NPAIR; p++) begin
                  in_duty[2*p]   = bv[bi] + p - 1;
                  in_duty[2*p+1] = in_R - bv[bi] + 2 * p;
                end
                run_cfg("R8 R9 R10");
              end

    // R6: mid-period change held until the next period start
    in_R = 6; in_P = 1; in_center = 0; in_inden = 1; in_pol = 0; in_D = 0;
    for (int k = 0; k < NCH; k++) in_duty[k] = k + 1;
    run_cfg("R6");
    in_R = 4; in_center = 1; in_inden = 1;
    for (int k = 0; k < NCH; k++) in_duty[k] = 5 - k;
    run_period(1'b1, "R6", 1'b1);
    latch_model();
    run_period(1'b1, "R6", 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule